// File: doc/BRIEF.md
# Functional Interrupt Recovery Controller

This block sits beside the read-compare path of a memory test sequencer. For every burst read back from the memory under test it counts the words that did not match the expected data. When that count is larger than a programmable threshold, the memory is taken to be in an unknown state and a recovery sequence starts. A busy output stalls the sequencer for as long as the sequence runs.

Recovery has two levels. The first level asks for the memory's configuration registers to be reloaded. It then asks for a re-read of the same data, with no new write. If the re-read burst is within the threshold, the fault counts as a soft event and monitoring resumes. If the re-read is still bad, the fault counts as a hard event and the second level runs. The supply enable is dropped for a programmable number of cycles, then raised again. After a programmable settling wait, a full initialization is requested. Both event counters saturate and share a synchronous clear.

The reload, re-read and initialization steps each use a simple request line that stays high until the sequencer acknowledges it. Re-read completion is signalled by the end of the next compared burst.

Top module: `fi_recovery_ctrl`

## Requirements
- R1: After reset, or when reset is applied during a recovery, busy_o=0, pwr_en_o=1, all request outputs are 0 and both counters are 0.
- R2: A burst whose mismatch count (words with cmp_err_i=1, up to and including the word with cmp_last_i=1) is less than or equal to thresh_i starts no recovery. The count restarts at zero after every burst.
- R3: When a burst ends with a mismatch count above thresh_i, reload_req_o rises two cycles after the last word is sampled. It stays high, with pwr_en_o=1, until reload_ack_i is sampled high.
- R4: In the cycle after reload_ack_i is sampled, reload_req_o falls and reread_req_o rises. reread_req_o stays high until the re-read burst ends, and no write or power action is requested.
- R5: If the re-read burst's mismatch count is at most thresh_i, soft_cnt_o increases by one and busy_o falls, both one cycle after the burst's last word is judged. hard_cnt_o does not change.
- R6: If the re-read burst is above thresh_i, hard_cnt_o increases by one and pwr_en_o goes low for exactly max(off_cycles_i,1) cycles. soft_cnt_o does not change.
- R7: After power returns, pwr_en_o stays high for max(on_wait_i,1) cycles before init_req_o rises. init_req_o then holds until init_ack_i is sampled, and busy_o falls in the next cycle.
- R8: busy_o is high whenever any request is pending or the supply is off.
- R9: The counters saturate at 2^CNT_W-1 and hold there.
- R10: cnt_clr_i=1 sets both counters to zero at the next clock edge. The clear takes priority over an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_valid_i | input | 1 | A compared read word is present |
| cmp_err_i | input | 1 | The present word mismatched |
| cmp_last_i | input | 1 | The present word ends its burst |
| thresh_i | input | ACC_W | Largest mismatch count still treated as a known state |
| off_cycles_i | input | TMR_W | Supply-off interval in cycles |
| on_wait_i | input | TMR_W | Settling wait after power returns, in cycles |
| reload_req_o | output | 1 | Request to reload the configuration registers |
| reload_ack_i | input | 1 | The register reload is done |
| reread_req_o | output | 1 | Request to re-read the memory without rewriting it |
| init_req_o | output | 1 | Request for a full memory initialization |
| init_ack_i | input | 1 | The initialization is done |
| pwr_en_o | output | 1 | Supply enable for the memory under test |
| busy_o | output | 1 | Recovery in progress; stalls the sequencer |
| cnt_clr_i | input | 1 | Synchronous clear of both counters |
| soft_cnt_o | output | CNT_W | Soft event count |
| hard_cnt_o | output | CNT_W | Hard event count |

## Verification
The assertions check, on every cycle, the properties that do not depend on timing:
- busy_o covers every pending request and the supply-off period.
- Requests never overlap.
- The supply is on while a reload or initialization is requested.
- The counters never step backwards except on a clear, and they stick at saturation.
- A clear zeroes both counters.

Only the bench scenarios can show the rest:
- the threshold boundary, where a count equal to the threshold is benign;
- that the mismatch count restarts for each burst;
- which event class a given re-read outcome produces;
- the exact lengths of the power-off and settling windows, including zero-valued settings.

// File: rtl/fi_rec_pkg.sv
package fi_rec_pkg;
  typedef enum logic [2:0] {
    ST_MON,
    ST_RELOAD,
    ST_REREAD,
    ST_PWR_OFF,
    ST_PWR_WAIT,
    ST_INIT
  } rec_state_e;
endpackage

// File: rtl/fi_burst_judge.sv
module fi_burst_judge #(
  parameter int ACC_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_valid_i,
  input  logic             cmp_err_i,
  input  logic             cmp_last_i,
  input  logic [ACC_W-1:0] thresh_i,
  output logic             verdict_v_o,
  output logic             verdict_bad_o
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_nx;

  always_comb begin
    acc_nx = acc_q;
    if (cmp_valid_i && cmp_err_i && acc_q != ACC_MAX) acc_nx = acc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q         <= '0;
      verdict_v_o   <= 1'b0;
      verdict_bad_o <= 1'b0;
    end else begin
      verdict_v_o   <= cmp_valid_i && cmp_last_i;
      verdict_bad_o <= cmp_valid_i && cmp_last_i && (acc_nx > thresh_i);
      // count restarts for each burst
      if (cmp_valid_i && cmp_last_i) acc_q <= '0;
      else                           acc_q <= acc_nx;
    end
  end
endmodule

// File: rtl/fi_rec_fsm.sv
module fi_rec_fsm
  import fi_rec_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             verdict_v_i,
  input  logic             verdict_bad_i,
  input  logic             reload_ack_i,
  input  logic             init_ack_i,
  input  logic [TMR_W-1:0] off_cycles_i,
  input  logic [TMR_W-1:0] on_wait_i,
  output logic             reload_req_o,
  output logic             reread_req_o,
  output logic             init_req_o,
  output logic             pwr_en_o,
  output logic             busy_o,
  output logic             soft_inc_o,
  output logic             hard_inc_o
);
  rec_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W:0]   tmr_nx;
  logic             off_done, wait_done;

  assign tmr_nx    = {1'b0, tmr_q} + 1'b1;
  // a zero setting still gives one cycle
  assign off_done  = tmr_nx >= {1'b0, off_cycles_i};
  assign wait_done = tmr_nx >= {1'b0, on_wait_i};

  always_comb begin
    state_d    = state_q;
    soft_inc_o = 1'b0;
    hard_inc_o = 1'b0;
    unique case (state_q)
      ST_MON:      if (verdict_v_i && verdict_bad_i) state_d = ST_RELOAD;
      ST_RELOAD:   if (reload_ack_i) state_d = ST_REREAD;
      ST_REREAD: begin
        if (verdict_v_i) begin
          if (verdict_bad_i) begin
            state_d    = ST_PWR_OFF;
            hard_inc_o = 1'b1;
          end else begin
            state_d    = ST_MON;
            soft_inc_o = 1'b1;
          end
        end
      end
      ST_PWR_OFF:  if (off_done) state_d = ST_PWR_WAIT;
      ST_PWR_WAIT: if (wait_done) state_d = ST_INIT;
      ST_INIT:     if (init_ack_i) state_d = ST_MON;
      default:     state_d = ST_MON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_MON;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) tmr_q <= '0;
      else                    tmr_q <= tmr_nx[TMR_W-1:0];
    end
  end

  assign reload_req_o = state_q == ST_RELOAD;
  assign reread_req_o = state_q == ST_REREAD;
  assign init_req_o   = state_q == ST_INIT;
  assign pwr_en_o     = state_q != ST_PWR_OFF;
  assign busy_o       = state_q != ST_MON;
endmodule

// File: rtl/fi_sat_counter.sv
module fi_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (clr_i)                      cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/fi_recovery_ctrl.sv
module fi_recovery_ctrl #(
  parameter int MAX_BURST = 64,
  parameter int TMR_W     = 16,
  parameter int CNT_W     = 16,
  localparam int ACC_W    = $clog2(MAX_BURST + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_valid_i,
  input  logic             cmp_err_i,
  input  logic             cmp_last_i,
  input  logic [ACC_W-1:0] thresh_i,
  input  logic [TMR_W-1:0] off_cycles_i,
  input  logic [TMR_W-1:0] on_wait_i,
  output logic             reload_req_o,
  input  logic             reload_ack_i,
  output logic             reread_req_o,
  output logic             init_req_o,
  input  logic             init_ack_i,
  output logic             pwr_en_o,
  output logic             busy_o,
  input  logic             cnt_clr_i,
  output logic [CNT_W-1:0] soft_cnt_o,
  output logic [CNT_W-1:0] hard_cnt_o
);
  logic             verdict_v, verdict_bad;
  logic [1:0]       inc;
  logic [CNT_W-1:0] cnt [2];

  fi_burst_judge #(.ACC_W(ACC_W)) u_judge (
    .clk_i, .rst_ni, .cmp_valid_i, .cmp_err_i, .cmp_last_i, .thresh_i,
    .verdict_v_o(verdict_v), .verdict_bad_o(verdict_bad)
  );

  fi_rec_fsm #(.TMR_W(TMR_W)) u_fsm (
    .clk_i, .rst_ni,
    .verdict_v_i(verdict_v), .verdict_bad_i(verdict_bad),
    .reload_ack_i, .init_ack_i, .off_cycles_i, .on_wait_i,
    .reload_req_o, .reread_req_o, .init_req_o, .pwr_en_o, .busy_o,
    .soft_inc_o(inc[0]), .hard_inc_o(inc[1])
  );

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    fi_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .clr_i(cnt_clr_i), .inc_i(inc[g]), .cnt_o(cnt[g])
    );
  end

  assign soft_cnt_o = cnt[0];
  assign hard_cnt_o = cnt[1];
endmodule

// File: rtl/fi_recovery_ctrl_chk.sv
module fi_recovery_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reload_req_o,
  input logic             reread_req_o,
  input logic             init_req_o,
  input logic             pwr_en_o,
  input logic             busy_o,
  input logic             cnt_clr_i,
  input logic [CNT_W-1:0] soft_cnt_o,
  input logic [CNT_W-1:0] hard_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R8
  busy_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_req_o || reread_req_o || init_req_o || !pwr_en_o) |-> busy_o);

  // R4
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reload_req_o, reread_req_o, init_req_o, !pwr_en_o}));

  // R3
  reload_pwr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_req_o |-> pwr_en_o);

  // R7
  init_pwr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_req_o |-> pwr_en_o);

  // R5
  soft_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !cnt_clr_i) |=> soft_cnt_o >= $past(soft_cnt_o));

  // R6
  hard_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !cnt_clr_i) |=> hard_cnt_o >= $past(hard_cnt_o));

  // R9
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_cnt_o == CNT_MAX && !cnt_clr_i) |=> soft_cnt_o == CNT_MAX);

  // R10
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (soft_cnt_o == '0 && hard_cnt_o == '0));
endmodule

bind fi_recovery_ctrl fi_recovery_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/fi_recovery_ctrl_bench.sv
module fi_recovery_ctrl_bench;
  localparam int MAX_BURST = 64;
  localparam int TMR_W     = 8;
  localparam int CNT_W     = 3;
  localparam int ACC_W     = $clog2(MAX_BURST + 1);
  localparam int BL        = 8;

  typedef struct packed {
    logic [7:0] thr;
    logic [7:0] e1;
    logic [7:0] e2;
    logic [7:0] off;
    logic [7:0] wt;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{8'd2, 8'd2, 8'd0, 8'd4, 8'd2},
    '{8'd2, 8'd3, 8'd0, 8'd4, 8'd2},
    '{8'd0, 8'd1, 8'd1, 8'd5, 8'd3},
    '{8'd3, 8'd8, 8'd4, 8'd0, 8'd0},
    '{8'd7, 8'd8, 8'd7, 8'd2, 8'd2},
    '{8'd0, 8'd0, 8'd0, 8'd1, 8'd1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmp_valid_i = 0, cmp_err_i = 0, cmp_last_i = 0;
  logic [ACC_W-1:0] thresh_i = '0;
  logic [TMR_W-1:0] off_cycles_i = '0, on_wait_i = '0;
  logic reload_ack_i = 0, init_ack_i = 0, cnt_clr_i = 0;
  logic reload_req_o, reread_req_o, init_req_o, pwr_en_o, busy_o;
  logic [CNT_W-1:0] soft_cnt_o, hard_cnt_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  fi_recovery_ctrl #(.MAX_BURST(MAX_BURST), .TMR_W(TMR_W), .CNT_W(CNT_W)) u_fi_recovery_ctrl (
    .clk_i(clk), .rst_ni, .cmp_valid_i, .cmp_err_i, .cmp_last_i, .thresh_i,
    .off_cycles_i, .on_wait_i, .reload_req_o, .reload_ack_i, .reread_req_o,
    .init_req_o, .init_ack_i, .pwr_en_o, .busy_o, .cnt_clr_i, .soft_cnt_o, .hard_cnt_o
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_burst(input int errs);
    for (int i = 0; i < BL; i++) begin
      cmp_valid_i = 1'b1;
      cmp_err_i   = (i < errs);
      cmp_last_i  = (i == BL - 1);
      tick();
    end
    cmp_valid_i = 1'b0;
    cmp_err_i   = 1'b0;
    cmp_last_i  = 1'b0;
  endtask

  task automatic run_vec(input int thr, input int e1, input int e2, input int off, input int wt);
    int s0, h0, n;
    thresh_i     = ACC_W'(thr);
    off_cycles_i = TMR_W'(off);
    on_wait_i    = TMR_W'(wt);
    s0 = int'(soft_cnt_o);
    h0 = int'(hard_cnt_o);
    send_burst(e1);
    tick();
    if (e1 <= thr) begin
      chk("R2 busy", busy_o, 0);
      chk("R2 reload_req", reload_req_o, 0);
      return;
    end
    chk("R8 busy", busy_o, 1);
    chk("R3 reload_req", reload_req_o, 1);
    chk("R3 pwr_en", pwr_en_o, 1);
    tick();
    tick();
    chk("R3 reload held", reload_req_o, 1);
    reload_ack_i = 1'b1;
    tick();
    reload_ack_i = 1'b0;
    chk("R4 reload_req low", reload_req_o, 0);
    chk("R4 reread_req", reread_req_o, 1);
    chk("R4 pwr_en", pwr_en_o, 1);
    send_burst(e2);
    tick();
    if (e2 <= thr) begin
      chk("R5 busy", busy_o, 0);
      chk("R5 soft", int'(soft_cnt_o), (s0 + 1 > 7) ? 7 : s0 + 1);
      chk("R5 hard", int'(hard_cnt_o), h0);
    end else begin
      chk("R6 hard", int'(hard_cnt_o), (h0 + 1 > 7) ? 7 : h0 + 1);
      chk("R6 soft", int'(soft_cnt_o), s0);
      n = 0;
      while (!pwr_en_o && n < 1000) begin n++; tick(); end
      chk("R6 off length", n, (off < 1) ? 1 : off);
      n = 0;
      while (!init_req_o && n < 1000) begin n++; tick(); end
      chk("R7 settle length", n, (wt < 1) ? 1 : wt);
      chk("R8 busy in init", busy_o, 1);
      tick();
      tick();
      chk("R7 init held", init_req_o, 1);
      init_ack_i = 1'b1;
      tick();
      init_ack_i = 1'b0;
      chk("R7 busy released", busy_o, 0);
      chk("R7 init_req low", init_req_o, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 busy", busy_o, 0);
    chk("R1 pwr_en", pwr_en_o, 1);
    chk("R1 reqs", {reload_req_o, reread_req_o, init_req_o}, 0);
    chk("R1 soft", int'(soft_cnt_o), 0);
    chk("R1 hard", int'(hard_cnt_o), 0);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v].thr, VEC[v].e1, VEC[v].e2, VEC[v].off, VEC[v].wt);
    chk("R5 soft total", int'(soft_cnt_o), 2);
    chk("R6 hard total", int'(hard_cnt_o), 2);

    // R2: no carry of mismatches across bursts
    thresh_i = ACC_W'(3);
    send_burst(2);
    send_burst(2);
    tick();
    chk("R2 per-burst count", busy_o, 0);

    // R9: saturation
    for (int k = 0; k < 7; k++) run_vec(1, 4, 0, 1, 1);
    chk("R9 saturated", int'(soft_cnt_o), 7);

    // R10: clear, priority over an increment
    cnt_clr_i = 1'b1;
    tick();
    cnt_clr_i = 1'b0;
    chk("R10 soft cleared", int'(soft_cnt_o), 0);
    chk("R10 hard cleared", int'(hard_cnt_o), 0);
    thresh_i = ACC_W'(0);
    send_burst(1);
    tick();
    reload_ack_i = 1'b1;
    tick();
    reload_ack_i = 1'b0;
    send_burst(0);
    cnt_clr_i = 1'b1;
    tick();
    cnt_clr_i = 1'b0;
    chk("R10 clear beats inc", int'(soft_cnt_o), 0);

    // R1: reset during recovery
    send_burst(2);
    tick();
    chk("R8 busy before reset", busy_o, 1);
    rst_ni = 1'b0;
    #1;
    chk("R1 mid reset busy", busy_o, 0);
    chk("R1 mid reset reload", reload_req_o, 0);
    chk("R1 mid reset pwr", pwr_en_o, 1);
    tick();
    rst_ni = 1'b1;
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule